// File: doc/BRIEF.md
# Mode Register Command Decoder

This block sits on the memory side of a DDR-style command bus. It watches chip select, the three strobes, clock enable, the bank address and the address bus on each rising clock edge. It picks out the load-mode command and, using bank address bit 0, steers the address bits into either the main mode register or the extended mode register. From the stored bits it presents the decoded operating configuration: read latency, burst length, burst ordering, test mode, DLL enable and output driver strength.

The block also keeps a bitmap of open banks, built from activate and precharge commands. A mode write that arrives while any bank is open, or while a previous mode write is still settling, is refused and flagged. A reserved code in a field keeps that field's previous value and raises a flag. A DLL reset request drops a lock indication for a fixed number of clocks. Every flag is a one-cycle pulse in the cycle after the offending command.

Top module: `mode_reg_decoder`

## Requirements
- R1: A command is seen only on a rising edge with cke_i high and cs_ni low. The load-mode command has ras_ni, cas_ni and we_ni all low. Activate has ras_ni low with cas_ni and we_ni high. Precharge has ras_ni and we_ni low with cas_ni high. Cycles with cke_i low or cs_ni high change nothing.
- R2: On a load-mode command, ba_i[0]=0 writes the main register and ba_i[0]=1 writes the extended register. A write to one register leaves the other's fields unchanged.
- R3: Main-register bits addr[2:0] give the burst length: 001 gives 2, 010 gives 4 and 011 gives 8. Any other code keeps the previous burst_len_o.
- R4: Main-register bits addr[6:4] give the read latency: 011 gives 3, 100 gives 4 and 101 gives 5. Any other code keeps the previous cas_lat_o.
- R5: Main-register bit addr[3] sets burst_ilv_o (0 sequential, 1 interleaved). Bit addr[7] sets test_mode_o.
- R6: Extended-register bit addr[0]=0 sets dll_en_o to 1, and addr[0]=1 sets it to 0. drv_strength_o takes {addr[6],addr[1]}, where 00 is normal, 01 is weak and 11 is matched. Code 10 is reserved and keeps the previous value.
- R7: Activate marks bank ba_i open. Precharge closes bank ba_i, or closes all banks when addr[10] is 1. A load-mode command while any bank is open changes no field and pulses err_bank_open_o for one cycle.
- R8: An accepted load-mode command holds busy_o high for the 2 cycles after its edge. A load-mode command arriving while busy_o is high is refused, changes no field and pulses err_busy_o. This check takes priority over the open-bank check.
- R9: An accepted main-register write with addr[8]=1 drives dll_locked_o low for exactly 200 cycles after its edge.
- R10: After reset the outputs are: latency 3, burst length 2, sequential, test mode off, DLL enabled, drive 00, busy low, locked high, all banks closed and no error pulses.
- R11: An accepted write that carries a reserved burst, latency or drive code pulses err_reserved_o for one cycle. Its valid fields are still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; commands are ignored while low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address; bit 0 selects the register on load-mode |
| addr_i | input | 12 | Address bus carrying the register contents |
| cas_lat_o | output | 3 | Read latency in clocks (3, 4 or 5) |
| burst_len_o | output | 4 | Burst length in beats (2, 4 or 8) |
| burst_ilv_o | output | 1 | 1 for interleaved burst order |
| test_mode_o | output | 1 | Test mode bit |
| dll_en_o | output | 1 | DLL enabled |
| drv_strength_o | output | 2 | Driver strength code |
| dll_locked_o | output | 1 | Low while the DLL lock wait runs |
| busy_o | output | 1 | Mode write settling |
| err_bank_open_o | output | 1 | Pulse: mode write refused, bank open |
| err_busy_o | output | 1 | Pulse: mode write refused, busy |
| err_reserved_o | output | 1 | Pulse: reserved code ignored |

## Verification
On every cycle the assertions check the following. Latency and burst length always hold a legal value. The configuration does not move after a refused, gated or busy-time command. busy_o and a falling dll_locked_o only ever follow a load-mode command on the bus. The bench's scenarios are needed for the rest. They show the bank bitmap through open, partial-close and close-all sequences. They show the per-field keep-on-reserved behaviour and the separation of the two register spaces. They also show the exact 200-cycle length of the lock wait, which a property cannot relate to its start without looking back a parameter-sized distance.

// File: rtl/mrd_pkg.sv
`timescale 1ns/1ps
package mrd_pkg;
  typedef enum logic [1:0] {CMD_NONE, CMD_ACT, CMD_PRE, CMD_MRS} cmd_e;

  // address bit positions decoded by the memory core
  localparam int BL_LSB  = 0;
  localparam int BT_BIT  = 3;
  localparam int CL_LSB  = 4;
  localparam int TM_BIT  = 7;
  localparam int DLR_BIT = 8;
  localparam int AP_BIT  = 10;
  localparam int DLE_BIT = 0;
  localparam int DRL_BIT = 1;
  localparam int DRH_BIT = 6;

  typedef struct packed {
    logic [2:0] cas_lat;
    logic [3:0] burst_len;
    logic       burst_ilv;
    logic       test_mode;
    logic       dll_en;
    logic [1:0] drv;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{cas_lat: 3'd3, burst_len: 4'd2, burst_ilv: 1'b0,
                                 test_mode: 1'b0, dll_en: 1'b1, drv: 2'b00};

  function automatic logic [4:0] bl_decode(input logic [2:0] code);
    // {valid, length}
    case (code)
      3'b001:  return {1'b1, 4'd2};
      3'b010:  return {1'b1, 4'd4};
      3'b011:  return {1'b1, 4'd8};
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [3:0] cl_decode(input logic [2:0] code);
    case (code)
      3'b011:  return {1'b1, 3'd3};
      3'b100:  return {1'b1, 3'd4};
      3'b101:  return {1'b1, 3'd5};
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/mrd_cmd_decode.sv
`timescale 1ns/1ps
module mrd_cmd_decode
  import mrd_pkg::*;
(
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    if (cke_i && !cs_ni && !ras_ni) begin
      unique case ({cas_ni, we_ni})
        2'b00:   cmd_o = CMD_MRS;
        2'b11:   cmd_o = CMD_ACT;
        2'b10:   cmd_o = CMD_PRE;
        default: cmd_o = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mrd_bank_track.sv
`timescale 1ns/1ps
module mrd_bank_track
  import mrd_pkg::*;
#(
  parameter int BANK_W = 2,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic              all_i,
  output logic              any_open_o
);
  logic [NBANK-1:0] open_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[b] <= 1'b0;
      end else if (cmd_i == CMD_ACT && ba_i == BANK_W'(b)) begin
        open_q[b] <= 1'b1;
      end else if (cmd_i == CMD_PRE && (all_i || ba_i == BANK_W'(b))) begin
        open_q[b] <= 1'b0;
      end
    end
  end

  assign any_open_o = |open_q;
endmodule

// File: rtl/mrd_countdown.sv
`timescale 1ns/1ps
module mrd_countdown #(
  parameter int CYCLES = 2,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic active_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/mrd_cfg_regs.sv
`timescale 1ns/1ps
module mrd_cfg_regs
  import mrd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_main_i,
  input  logic              wr_ext_i,
  input  logic [ADDR_W-1:0] addr_i,
  output cfg_t              cfg_o,
  output logic              bad_code_o
);
  cfg_t       cfg_q, cfg_d;
  logic [4:0] bl_dec;
  logic [3:0] cl_dec;
  logic [1:0] drv_code;

  assign bl_dec   = bl_decode(addr_i[BL_LSB +: 3]);
  assign cl_dec   = cl_decode(addr_i[CL_LSB +: 3]);
  assign drv_code = {addr_i[DRH_BIT], addr_i[DRL_BIT]};

  always_comb begin
    cfg_d      = cfg_q;
    bad_code_o = 1'b0;
    if (wr_main_i) begin
      if (bl_dec[4]) cfg_d.burst_len = bl_dec[3:0];
      else           bad_code_o      = 1'b1;
      if (cl_dec[3]) cfg_d.cas_lat   = cl_dec[2:0];
      else           bad_code_o      = 1'b1;
      cfg_d.burst_ilv = addr_i[BT_BIT];
      cfg_d.test_mode = addr_i[TM_BIT];
    end else if (wr_ext_i) begin
      cfg_d.dll_en = ~addr_i[DLE_BIT];
      if (drv_code != 2'b10) cfg_d.drv = drv_code;
      else                   bad_code_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RESET;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/mode_reg_decoder.sv
`timescale 1ns/1ps
module mode_reg_decoder
  import mrd_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BANK_W      = 2,
  parameter int MRD_CYCLES  = 2,
  parameter int LOCK_CYCLES = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [2:0]        cas_lat_o,
  output logic [3:0]        burst_len_o,
  output logic              burst_ilv_o,
  output logic              test_mode_o,
  output logic              dll_en_o,
  output logic [1:0]        drv_strength_o,
  output logic              dll_locked_o,
  output logic              busy_o,
  output logic              err_bank_open_o,
  output logic              err_busy_o,
  output logic              err_reserved_o
);
  cmd_e cmd;
  logic any_open, busy, lock_wait, bad_code;
  logic accept, wr_main, wr_ext;
  cfg_t cfg;

  mrd_cmd_decode u_cmd (
    .cke_i(cke_i), .cs_ni(cs_ni), .ras_ni(ras_ni),
    .cas_ni(cas_ni), .we_ni(we_ni), .cmd_o(cmd)
  );

  mrd_bank_track #(.BANK_W(BANK_W)) u_banks (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd), .ba_i(ba_i),
    .all_i(addr_i[AP_BIT]), .any_open_o(any_open)
  );

  // busy has priority over the open-bank check
  assign accept  = (cmd == CMD_MRS) && !busy && !any_open;
  assign wr_main = accept && !ba_i[0];
  assign wr_ext  = accept &&  ba_i[0];

  mrd_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_main_i(wr_main), .wr_ext_i(wr_ext),
    .addr_i(addr_i), .cfg_o(cfg), .bad_code_o(bad_code)
  );

  mrd_countdown #(.CYCLES(MRD_CYCLES)) u_busy (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .active_o(busy)
  );

  mrd_countdown #(.CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wr_main && addr_i[DLR_BIT]),
    .active_o(lock_wait)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_bank_open_o <= 1'b0;
      err_busy_o      <= 1'b0;
      err_reserved_o  <= 1'b0;
    end else begin
      err_busy_o      <= (cmd == CMD_MRS) && busy;
      err_bank_open_o <= (cmd == CMD_MRS) && !busy && any_open;
      err_reserved_o  <= bad_code;
    end
  end

  assign cas_lat_o      = cfg.cas_lat;
  assign burst_len_o    = cfg.burst_len;
  assign burst_ilv_o    = cfg.burst_ilv;
  assign test_mode_o    = cfg.test_mode;
  assign dll_en_o       = cfg.dll_en;
  assign drv_strength_o = cfg.drv;
  assign busy_o         = busy;
  assign dll_locked_o   = !lock_wait;
endmodule

// File: rtl/mrd_checker.sv
`timescale 1ns/1ps
module mrd_checker #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_i,
  input logic              cs_ni,
  input logic              ras_ni,
  input logic              cas_ni,
  input logic              we_ni,
  input logic [BANK_W-1:0] ba_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [2:0]        cas_lat_o,
  input logic [3:0]        burst_len_o,
  input logic              burst_ilv_o,
  input logic              dll_en_o,
  input logic [1:0]        drv_strength_o,
  input logic              dll_locked_o,
  input logic              busy_o,
  input logic              err_bank_open_o,
  input logic              err_busy_o
);
  logic lm_cmd;
  assign lm_cmd = cke_i && !cs_ni && !ras_ni && !cas_ni && !we_ni;

  // R4
  cl_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_lat_o inside {3'd3, 3'd4, 3'd5});

  // R3
  bl_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_len_o inside {4'd2, 4'd4, 4'd8});

  // R1
  gated_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!cke_i || cs_ni) |-> ($stable(cas_lat_o) && $stable(burst_len_o) &&
      $stable(burst_ilv_o) && $stable(dll_en_o) && $stable(drv_strength_o)));

  // R7
  bank_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_bank_open_o |-> ($stable(cas_lat_o) && $stable(burst_len_o) &&
      $stable(dll_en_o) && $stable(drv_strength_o)));

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(cas_lat_o) && $stable(burst_len_o) &&
      $stable(dll_en_o) && $stable(drv_strength_o)));

  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(lm_cmd));

  // R8
  busy_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_busy_o |-> $past(busy_o));

  // R9
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dll_locked_o) |-> $past(lm_cmd && !ba_i[0] && addr_i[8]));
endmodule

bind mode_reg_decoder mrd_checker #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni),
  .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .ba_i(ba_i),
  .addr_i(addr_i), .cas_lat_o(cas_lat_o), .burst_len_o(burst_len_o),
  .burst_ilv_o(burst_ilv_o), .dll_en_o(dll_en_o),
  .drv_strength_o(drv_strength_o), .dll_locked_o(dll_locked_o),
  .busy_o(busy_o), .err_bank_open_o(err_bank_open_o), .err_busy_o(err_busy_o)
);

// File: tb/mode_reg_decoder_tb.sv
`timescale 1ns/1ps
module mode_reg_decoder_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [2:0]  cas_lat;
  logic [3:0]  burst_len;
  logic        burst_ilv, test_mode, dll_en, dll_locked, busy;
  logic [1:0]  drv;
  logic        err_bank, err_busy, err_res;

  always #2.5 clk = ~clk;

  mode_reg_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr),
    .cas_lat_o(cas_lat), .burst_len_o(burst_len), .burst_ilv_o(burst_ilv),
    .test_mode_o(test_mode), .dll_en_o(dll_en), .drv_strength_o(drv),
    .dll_locked_o(dll_locked), .busy_o(busy), .err_bank_open_o(err_bank),
    .err_busy_o(err_busy), .err_reserved_o(err_res)
  );

  typedef struct {
    string tag;
    int cl, bl;
    bit bt, tm, den, bsy, lck, eb, ebz, er;
    bit [1:0] dv;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int m_cl = 3, m_bl = 2, m_busy = 0, m_lock = 0;
  bit m_bt = 0, m_tm = 0, m_den = 1;
  bit [1:0] m_dv = 2'b00;
  bit [3:0] m_open = 4'b0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, bit k, bit c, bit r, bit s, bit w,
                       bit [1:0] b, bit [11:0] a);
    exp_t e;
    bit lm, act, pre, acc;
    @(negedge clk);
    cke = k; cs_n = c; ras_n = r; cas_n = s; we_n = w; ba = b; addr = a;
    @(posedge clk);
    #1;
    lm  = k && !c && !r && !s && !w;
    act = k && !c && !r &&  s &&  w;
    pre = k && !c && !r &&  s && !w;
    e.tag = tag; e.eb = 0; e.ebz = 0; e.er = 0;
    acc = 0;
    if (lm) begin
      if (m_busy > 0)        e.ebz = 1;
      else if (m_open != 0)  e.eb = 1;
      else                   acc = 1;
    end
    if (acc && !b[0]) begin
      case (a[2:0]) 3'b001: m_bl = 2; 3'b010: m_bl = 4; 3'b011: m_bl = 8; default: e.er = 1; endcase
      case (a[6:4]) 3'b011: m_cl = 3; 3'b100: m_cl = 4; 3'b101: m_cl = 5; default: e.er = 1; endcase
      m_bt = a[3]; m_tm = a[7];
    end else if (acc) begin
      m_den = !a[0];
      if ({a[6], a[1]} == 2'b10) e.er = 1; else m_dv = {a[6], a[1]};
    end
    m_busy = acc ? 2 : (m_busy > 0 ? m_busy - 1 : 0);
    m_lock = (acc && !b[0] && a[8]) ? 200 : (m_lock > 0 ? m_lock - 1 : 0);
    if (act) m_open[b] = 1;
    if (pre) begin
      if (a[10]) m_open = 0; else m_open[b] = 0;
    end
    e.cl = m_cl; e.bl = m_bl; e.bt = m_bt; e.tm = m_tm; e.den = m_den; e.dv = m_dv;
    e.bsy = (m_busy != 0); e.lck = (m_lock == 0);
    q.push_back(e);
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) drive("R1 idle", 1, 1, 1, 1, 1, 2'b00, 12'h000);
  endtask
  task automatic lmr(string tag, bit [1:0] b, bit [11:0] a);
    drive(tag, 1, 0, 0, 0, 0, b, a);
  endtask
  task automatic actv(string tag, bit [1:0] b);
    drive(tag, 1, 0, 0, 1, 1, b, 12'h000);
  endtask
  task automatic prech(string tag, bit [1:0] b, bit all);
    drive(tag, 1, 0, 0, 1, 0, b, all ? 12'h400 : 12'h000);
  endtask

  // monitor: compare each produced cycle against the queued expectation
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(cas_lat == 3'(e.cl),   {e.tag, " / R4 latency"}, cas_lat, e.cl);
      check(burst_len == 4'(e.bl), {e.tag, " / R3 burst length"}, burst_len, e.bl);
      check(burst_ilv == e.bt,     {e.tag, " / R5 burst order"}, burst_ilv, e.bt);
      check(test_mode == e.tm,     {e.tag, " / R5 test mode"}, test_mode, e.tm);
      check(dll_en == e.den,       {e.tag, " / R6 dll enable"}, dll_en, e.den);
      check(drv == e.dv,           {e.tag, " / R6 drive"}, drv, e.dv);
      check(busy == e.bsy,         {e.tag, " / R8 busy"}, busy, e.bsy);
      check(err_busy == e.ebz,     {e.tag, " / R8 busy error"}, err_busy, e.ebz);
      check(dll_locked == e.lck,   {e.tag, " / R9 locked"}, dll_locked, e.lck);
      check(err_bank == e.eb,      {e.tag, " / R7 bank error"}, err_bank, e.eb);
      check(err_res == e.er,       {e.tag, " / R11 reserved error"}, err_res, e.er);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    // R10 reset state
    check(cas_lat == 3 && burst_len == 2 && !burst_ilv && !test_mode, "R10 reset fields", cas_lat, 3);
    check(dll_en && drv == 2'b00 && dll_locked && !busy, "R10 reset dll/busy", {dll_en, dll_locked, busy}, 3'b110);
    check(!err_bank && !err_busy && !err_res, "R10 reset errors", {err_bank, err_busy, err_res}, 0);

    lmr("R2 main write cl4 bl4", 2'b00, 12'h042);
    nop(2);
    lmr("R8 write then", 2'b00, 12'h05B);
    lmr("R8 write while busy", 2'b00, 12'h031);
    nop(2);
    drive("R1 cke low", 0, 0, 0, 0, 0, 2'b00, 12'h033);
    drive("R1 cs high", 1, 1, 0, 0, 0, 2'b00, 12'h033);
    drive("R1 refresh-like ignored", 1, 0, 0, 0, 1, 2'b00, 12'h033);
    nop(2);
    lmr("R3 reserved bl keeps", 2'b00, 12'h030);
    nop(2);
    lmr("R4 reserved cl keeps", 2'b00, 12'h071);
    nop(2);
    lmr("R4 cl5 bl8 interleave", 2'b00, 12'h05B);
    nop(2);
    lmr("R2 ext dll off matched", 2'b01, 12'h043);
    nop(2);
    lmr("R6 ext reserved drive", 2'b01, 12'h040);
    nop(2);
    lmr("R6 ext weak dll on", 2'b01, 12'h002);
    nop(2);
    actv("R7 open bank2", 2'b10);
    lmr("R7 write with open bank", 2'b00, 12'h042);
    prech("R7 close bank1 only", 2'b01, 0);
    lmr("R7 still open", 2'b00, 12'h042);
    prech("R7 close bank2", 2'b10, 0);
    lmr("R7 accepted after close", 2'b00, 12'h0B2);
    nop(2);
    actv("R7 open bank0", 2'b00);
    actv("R7 open bank3", 2'b11);
    prech("R7 close all", 2'b01, 1);
    lmr("R7 accepted after close all", 2'b00, 12'h032);
    actv("R8 act during busy", 2'b01);
    lmr("R8 busy beats open bank", 2'b00, 12'h042);
    prech("R7 close", 2'b01, 1);
    nop(1);
    lmr("R9 dll reset", 2'b00, 12'h142);
    nop(205);
    lmr("R9 dll reset again", 2'b00, 12'h131);
    nop(3);
    lmr("R9 ext write no reset", 2'b01, 12'h100);
    nop(202);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule